// File: doc/BRIEF.md
# Dual Waveform RAM Access Controller

This block owns two waveform memories, A and B. Each memory word holds eight 14-bit sample points. The block lets a slow control side load these memories and read them back one word at a time. When no access is active, it streams both memories out in the fast sample clock domain.

The control side works through two toggle-signalled ports:

- A 26-bit control word sets up an access. It holds the start address, the burst length in eight-point words, the direction, the target memory, a mirror option and a start command.
- A word port carries one data word, or one read request, per toggle.

Both toggle lines are resynchronised into the sample clock domain. The design assumes the sample clock runs more than 16 times faster than the control side. On that assumption, a toggle and the data that goes with it are always settled before they are used.

While the start bit is set, each word transfer either writes the current address or returns the word stored there. The address then advances. After the last word of the burst, the start bit clears itself and playback resumes. During playback both memories are read at a free-running address that steps once per sample clock and wraps at the top of the address space.

Top module: `dual_wave_ram_ctrl`

## Requirements
- R1: Bits [10:0] of the control word give the first word address. Bits [21:11] give the burst code. An access moves code+1 words, so a code of 0 is a single-word access.
- R2: Bit 22 selects the direction: 1 writes, 0 reads. A read request returns the addressed word on `rd_data` with `rd_valid` high for one cycle.
- R3: With bit 24 clear, bit 23 selects the memory: 0 for RAM A, 1 for RAM B. For reads, bit 23 alone picks the source memory.
- R4: With bit 24 set, a write stores the same word into both RAM A and RAM B.
- R5: Setting bit 25 starts an access. The bit stays set until the last word of the burst has been transferred, then reads back as 0 on `cfg_rb`. The other fields keep their values.
- R6: A word toggle that arrives while bit 25 is clear changes no memory and produces no `rd_valid`.
- R7: The access address advances by one per word transferred. It wraps from 2047 to 0.
- R8: While bit 25 is clear, `pb_vld` is high. `pb_addr` then steps by one every cycle and wraps from 2047 to 0. `pb_a` and `pb_b` carry the contents of RAM A and RAM B at `pb_addr`. `rd_valid` and `pb_vld` are never high together.
- R9: After reset, `cfg_rb` is zero, `rd_valid` is low, and playback runs.
- R10: Every change of level on `cfg_tgl` loads one control word. Every change of level on `wd_tgl` performs one word transfer. Both rising and falling changes count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tgl | input | 1 | Toggles once per new control word |
| cfg_word | input | 26 | Control word, held stable around a toggle |
| wd_tgl | input | 1 | Toggles once per word transfer |
| wd_data | input | 112 | Write data: eight 14-bit points, point 0 in bits [13:0] |
| cfg_rb | output | 26 | Current control register; bit 25 clears itself |
| rd_data | output | 112 | Word returned by a read transfer |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` |
| pb_a | output | 112 | Playback word from RAM A |
| pb_b | output | 112 | Playback word from RAM B |
| pb_addr | output | 11 | Address of the playback words shown |
| pb_vld | output | 1 | Playback outputs are valid |

## Verification
A wrong address counter or burst counter becomes visible on `cfg_rb` one word toggle after it goes wrong. It shows as a start bit that clears too early or stays set. It also shows as read-back data taken from the wrong address, which differs on every point of the word. A misrouted write enable leaves the stale word in one memory. That stale word appears on `rd_data` at the next read of that address, and on `pb_a` or `pb_b` within one 2048-cycle playback sweep. A broken playback counter breaks the step-by-one sequence on `pb_addr` in the very next cycle.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
    localparam int ADDR_W  = 11;
    localparam int PT_W    = 14;
    localparam int PTS     = 8;
    localparam int WORD_W  = PT_W * PTS;
    localparam int CTRL_W  = 2 * ADDR_W + 4;

    typedef struct packed {
        logic              start;
        logic              both;
        logic              sel_b;
        logic              wr;
        logic [ADDR_W-1:0] burst;
        logic [ADDR_W-1:0] addr;
    } ctrl_t;

    function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
        return a + 1'b1;
    endfunction
endpackage

// File: rtl/wrc_tgl_sync.sv
module wrc_tgl_sync (
    input  logic clk,
    input  logic rst,
    input  logic tgl_in,
    output logic pulse
);
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[1:0], tgl_in};
    end

    assign pulse = sh[2] ^ sh[1];
endmodule

// File: rtl/wrc_ram.sv
module wrc_ram #(
    parameter int AW = 11,
    parameter int DW = 112
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/wrc_access.sv
module wrc_access
    import wrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_pulse,
    input  ctrl_t             cfg_in,
    input  logic              word_pulse,
    output ctrl_t             ctrl_q,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              we_a,
    output logic              we_b,
    output logic              rd_req
);
    logic [ADDR_W-1:0] cnt;
    logic              xfer;

    assign xfer   = word_pulse && ctrl_q.start && !cfg_pulse;
    assign we_a   = xfer && ctrl_q.wr && (ctrl_q.both || !ctrl_q.sel_b);
    assign we_b   = xfer && ctrl_q.wr && (ctrl_q.both ||  ctrl_q.sel_b);
    assign rd_req = xfer && !ctrl_q.wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            acc_addr <= '0;
            cnt      <= '0;
        end else if (cfg_pulse) begin
            ctrl_q   <= cfg_in;
            acc_addr <= cfg_in.addr;
            cnt      <= '0;
        end else if (xfer) begin
            acc_addr <= next_addr(acc_addr);
            if (cnt == ctrl_q.burst) begin
                ctrl_q.start <= 1'b0;
                cnt          <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dual_wave_ram_ctrl.sv
module dual_wave_ram_ctrl
    import wrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_tgl,
    input  logic [CTRL_W-1:0] cfg_word,
    input  logic              wd_tgl,
    input  logic [WORD_W-1:0] wd_data,
    output logic [CTRL_W-1:0] cfg_rb,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [WORD_W-1:0] pb_a,
    output logic [WORD_W-1:0] pb_b,
    output logic [ADDR_W-1:0] pb_addr,
    output logic              pb_vld
);
    localparam int NRAM = 2;

    logic              cfg_pulse, word_pulse;
    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] acc_addr, pb_ctr, raddr;
    logic              we_a, we_b, rd_req, rd_sel_q;
    logic [NRAM-1:0]   we;
    logic [WORD_W-1:0] q [NRAM];

    wrc_tgl_sync u_cfg_sync (.clk(clk), .rst(rst), .tgl_in(cfg_tgl), .pulse(cfg_pulse));
    wrc_tgl_sync u_wd_sync  (.clk(clk), .rst(rst), .tgl_in(wd_tgl),  .pulse(word_pulse));

    wrc_access u_acc (
        .clk(clk), .rst(rst),
        .cfg_pulse(cfg_pulse), .cfg_in(ctrl_t'(cfg_word)),
        .word_pulse(word_pulse),
        .ctrl_q(ctrl_q), .acc_addr(acc_addr),
        .we_a(we_a), .we_b(we_b), .rd_req(rd_req)
    );

    assign we    = {we_b, we_a};
    assign raddr = ctrl_q.start ? acc_addr : pb_ctr;

    for (genvar g = 0; g < NRAM; g++) begin : g_ram
        wrc_ram #(.AW(ADDR_W), .DW(WORD_W)) u_ram (
            .clk(clk), .we(we[g]), .waddr(acc_addr), .wdata(wd_data),
            .raddr(raddr), .rdata(q[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pb_ctr   <= '0;
            pb_addr  <= '0;
            pb_vld   <= 1'b0;
            rd_valid <= 1'b0;
            rd_sel_q <= 1'b0;
        end else begin
            if (!ctrl_q.start) pb_ctr <= next_addr(pb_ctr);
            pb_addr  <= pb_ctr;
            pb_vld   <= !ctrl_q.start;
            rd_valid <= rd_req;
            rd_sel_q <= ctrl_q.sel_b;
        end
    end

    assign cfg_rb  = CTRL_W'(ctrl_q);
    assign pb_a    = q[0];
    assign pb_b    = q[1];
    assign rd_data = rd_sel_q ? q[1] : q[0];
endmodule

// File: rtl/wrc_checker.sv
module wrc_checker
    import wrc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CTRL_W-1:0] cfg_rb,
    input logic              rd_valid,
    input logic              pb_vld,
    input logic [ADDR_W-1:0] pb_addr
);
    localparam logic [ADDR_W-1:0] TOP = '1;
    logic live;

    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    // R8
    pb_step_chk: assert property (@(posedge clk) disable iff (rst)
        (live && pb_vld && $past(pb_vld) && $past(pb_addr) != TOP) |-> pb_addr == $past(pb_addr) + 1'b1);

    // R8
    pb_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (live && pb_vld && $past(pb_vld) && $past(pb_addr) == TOP) |-> pb_addr == '0);

    // R8
    rd_pb_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && pb_vld));

    // R5
    rd_in_prog_chk: assert property (@(posedge clk) disable iff (rst)
        (live && rd_valid) |-> $past(cfg_rb[CTRL_W-1]));

    // R2
    rd_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (live && rd_valid) |-> !$past(cfg_rb[2*ADDR_W]));
endmodule

bind dual_wave_ram_ctrl wrc_checker u_chk (
    .clk(clk), .rst(rst), .cfg_rb(cfg_rb), .rd_valid(rd_valid),
    .pb_vld(pb_vld), .pb_addr(pb_addr)
);

// File: tb/test_dual_wave_ram_ctrl.sv
module test_dual_wave_ram_ctrl;
    import wrc_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_tgl = 1'b0;
    logic [CTRL_W-1:0] cfg_word = '0;
    logic              wd_tgl = 1'b0;
    logic [WORD_W-1:0] wd_data = '0;
    logic [CTRL_W-1:0] cfg_rb;
    logic [WORD_W-1:0] rd_data, pb_a, pb_b;
    logic              rd_valid, pb_vld;
    logic [ADDR_W-1:0] pb_addr;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    dual_wave_ram_ctrl i_dual_wave_ram_ctrl (
        .clk(clk), .rst(rst), .cfg_tgl(cfg_tgl), .cfg_word(cfg_word),
        .wd_tgl(wd_tgl), .wd_data(wd_data), .cfg_rb(cfg_rb),
        .rd_data(rd_data), .rd_valid(rd_valid), .pb_a(pb_a), .pb_b(pb_b),
        .pb_addr(pb_addr), .pb_vld(pb_vld)
    );

    // {addr[10:0], burst[10:0], sel_b, both, salt[7:0]}
    localparam int NV = 4;
    localparam logic [31:0] VEC [NV] = '{
        {11'd5,    11'd0, 1'b0, 1'b0, 8'd1},
        {11'd100,  11'd3, 1'b1, 1'b0, 8'd2},
        {11'd2046, 11'd2, 1'b0, 1'b1, 8'd3},
        {11'd300,  11'd1, 1'b0, 1'b0, 8'd4}
    };

    function automatic logic [WORD_W-1:0] pat(input logic [ADDR_W-1:0] a, input logic [7:0] s);
        logic [WORD_W-1:0] v;
        for (int p = 0; p < PTS; p++)
            v[p*PT_W +: PT_W] = PT_W'(int'(a) * 8 + p + int'(s) * 97);
        return v;
    endfunction

    function automatic logic [CTRL_W-1:0] mk(input logic st, input logic bo, input logic sb,
                                             input logic wr, input logic [10:0] bu, input logic [10:0] ad);
        return {st, bo, sb, wr, bu, ad};
    endfunction

    task automatic check(input string req, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_cfg(input logic [CTRL_W-1:0] w);
        @(negedge clk);
        cfg_word = w;
        cfg_tgl  = ~cfg_tgl;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_word(input logic [WORD_W-1:0] d);
        @(negedge clk);
        wd_data = d;
        wd_tgl  = ~wd_tgl;
        repeat (6) @(negedge clk);
    endtask

    // issues one read transfer, returns data and whether a strobe was seen
    task automatic read_word(output logic [WORD_W-1:0] d, output bit seen);
        seen = 0;
        d    = '0;
        @(negedge clk);
        wd_tgl = ~wd_tgl;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (rd_valid && !seen) begin
                seen = 1;
                d    = rd_data;
            end
        end
    endtask

    task automatic wait_pb(input logic [ADDR_W-1:0] a);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (pb_vld && pb_addr == a) return;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [WORD_W-1:0] d;
        bit seen;
        logic [10:0] a0, bu;
        logic sb, bo;
        logic [7:0] s;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 cfg_rb", WORD_W'(cfg_rb), '0);
        check("R9 rd_valid", WORD_W'(rd_valid), '0);
        check("R9 pb_vld", WORD_W'(pb_vld), 1);

        for (int v = 0; v < NV; v++) begin
            {a0, bu, sb, bo, s} = VEC[v];
            // R1 R3 R4 R10: write burst
            send_cfg(mk(1'b1, bo, sb, 1'b1, bu, a0));
            check("R5 start set", WORD_W'(cfg_rb[25]), 1);
            for (int k = 0; k <= int'(bu); k++) begin
                if (k == int'(bu))
                    check("R5 still busy before last word", WORD_W'(cfg_rb[25]), 1);
                send_word(pat(11'(int'(a0) + k), s));
            end
            // R5 self clear, R1 word count
            check("R5 start cleared", WORD_W'(cfg_rb[25]), 0);
            check("R5 fields kept", WORD_W'(cfg_rb[21:0]), WORD_W'({bu, a0}));
            // read back each targeted RAM; R2 R3 R7
            for (int r = 0; r < 2; r++) begin
                if (bo || (r == int'(sb))) begin
                    send_cfg(mk(1'b1, 1'b0, r[0], 1'b0, bu, a0));
                    for (int k = 0; k <= int'(bu); k++) begin
                        read_word(d, seen);
                        check("R2 rd_valid seen", WORD_W'(seen), 1);
                        check(bo ? "R4 mirror readback" : "R3 R7 readback", d, pat(11'(int'(a0) + k), s));
                    end
                    check("R1 read burst done", WORD_W'(cfg_rb[25]), 0);
                end
            end
            // R3: the untargeted RAM was not written (salted pattern absent)
            if (!bo) begin
                send_cfg(mk(1'b1, 1'b0, !sb, 1'b0, 11'd0, a0));
                read_word(d, seen);
                tests++;
                if (d === pat(a0, s)) begin
                    fails++;
                    $display("FAIL R3 other RAM actual=%h expected=not %h", d, pat(a0, s));
                end
            end
        end

        // R6: word toggles with start clear are ignored
        send_cfg(mk(1'b0, 1'b1, 1'b0, 1'b1, 11'd0, 11'd5));
        read_word(d, seen);
        check("R6 no strobe when idle", WORD_W'(seen), 0);
        send_word(pat(11'd5, 8'd200));
        send_cfg(mk(1'b1, 1'b0, 1'b0, 1'b0, 11'd0, 11'd5));
        read_word(d, seen);
        check("R6 RAM A unchanged", d, pat(11'd5, 8'd1));

        // R8 playback contents and wrap
        wait_pb(11'd100);
        check("R8 pb_b at 100", pb_b, pat(11'd100, 8'd2));
        wait_pb(11'd301);
        check("R8 pb_a at 301", pb_a, pat(11'd301, 8'd4));
        wait_pb(11'd2047);
        check("R8 pb_a at 2047", pb_a, pat(11'd2047, 8'd3));
        @(negedge clk);
        check("R8 wrap to 0", WORD_W'(pb_addr), 0);
        check("R7 R4 pb_b at 0", pb_b, pat(11'd0, 8'd3));
        check("R8 rd_valid low in playback", WORD_W'(rd_valid), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule